// File: doc/BRIEF.md
# Dual-Channel Double-Data-Rate Converter Sample Deserializer

This block sits at the receive edge of a two-channel 14-bit data converter whose outputs share a forwarded clock. Each channel delivers a sample on only seven lines. The even-numbered sample bits are present at the rising edge of that clock and the odd-numbered bits at the falling edge. The block captures on both edges, pairs the two halves of each clock period and rebuilds one full 14-bit word per channel per clock. The differential receivers are outside the block, so the lines are modelled as plain single-ended logic.

On top of the rebuilt stream, a small sequencer frames one capture window. A start pulse with a length of 1 to 16384 marks exactly that many consecutive clock cycles with a shared valid strobe. A one-cycle done pulse follows, and then the block returns to idle. The sequencer has three states. CAP_IDLE moves to CAP_RUN on an accepted start (transition "accept"). CAP_RUN stays in CAP_RUN while more than one sample remains (transition "count"), and moves to CAP_DONE on the last sample (transition "last"). CAP_DONE always returns to CAP_IDLE after one cycle (transition "finish"). A start in CAP_IDLE with an out-of-range length causes no transition (transition "reject"). A start in CAP_RUN or CAP_DONE causes no transition.

Top module: `adc_ddr_capture`

## Requirements
- R1: Data line k (k = 0..6) of a channel, sampled at the rising clock edge, becomes bit 2k of that channel's rebuilt word.
- R2: Data line k of a channel, sampled at the following falling clock edge, becomes bit 2k+1 of the same word.
- R3: The two halves captured in one clock period, at the rising edge at cycle t and the falling edge after it, appear together on the sample output after the rising edge at cycle t+1. The sample output updates every clock, whatever the sequencer state.
- R4: Both channels are rebuilt independently with identical timing, so any pair of values, including all-ones against all-zeros and opposite alternating-bit patterns, comes out intact on each.
- R5: While reset is low, both sample words are zero and valid, done and busy are low.
- R6: A start sampled in idle with a length N of 1 to 16384 raises valid at the next clock and holds it for exactly N consecutive cycles.
- R7: Done is high for exactly one cycle, the cycle right after the last valid cycle, and is never high together with valid. The block is idle in the cycle after done.
- R8: A start sampled while busy has no effect: the running capture keeps its original length.
- R9: A start sampled in idle with a length of 0, or of more than 16384, leaves the block idle with valid low.
- R10: Busy is high from the first valid cycle through the done cycle, and valid is only ever high while busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| adc_clk | input | 1 | Forwarded converter clock, also the capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ddr_a | input | 7 | Channel A double-data-rate lines |
| ddr_b | input | 7 | Channel B double-data-rate lines |
| start | input | 1 | Capture start pulse |
| cap_len | input | 15 | Number of samples to mark valid (1..16384) |
| samp_a | output | 14 | Rebuilt channel A sample |
| samp_b | output | 14 | Rebuilt channel B sample |
| samp_valid | output | 1 | Shared valid strobe for both channels |
| cap_done | output | 1 | One-cycle pulse after the last valid sample |
| busy | output | 1 | Capture window in progress |

## Verification
The assertions check the sequencer on every cycle. They check that valid and done never overlap, that done is a single pulse right after a valid cycle and is followed by idle, that an accepted or rejected start moves the state as it should, and that the number of valid cycles counted at done equals the length latched when the start was accepted. A start while busy therefore cannot change the count. Only the bench scenarios can show the bit interleaving and the one-clock pairing latency. For this the bench drives known words as rising and falling halves on every clock and compares each rebuilt word of both channels against values it computes itself. It uses all-ones, all-zeros, alternating and walking-one patterns, and runs captures of 1, 5, 37 and 16384 samples, plus rejected lengths.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_RUN  = 2'd1,
        CAP_DONE = 2'd2
    } cap_state_t;

endpackage

// File: rtl/ddr_lane_capture.sv
module ddr_lane_capture #(
    parameter int LINES = 7,
    localparam int WORD_W = 2 * LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  ddr_in,
    output logic [WORD_W-1:0] word
);

    logic [LINES-1:0] rise_q;
    logic [LINES-1:0] fall_q;

    // Even half, taken at the rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= ddr_in;
    end

    // Odd half, taken at the falling edge of the same period
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= ddr_in;
    end

    // Interleave both halves at the next rising edge
    for (genvar k = 0; k < LINES; k++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word[2*k]   <= 1'b0;
                word[2*k+1] <= 1'b0;
            end else begin
                word[2*k]   <= rise_q[k];
                word[2*k+1] <= fall_q[k];
            end
        end
    end

endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer
    import adc_cap_pkg::*;
#(
    parameter int MAX_COUNT = 16384,
    localparam int CNT_W = $clog2(MAX_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cap_len,
    output logic             valid,
    output logic             done,
    output logic             busy
);

    cap_state_t       state_q;
    cap_state_t       state_d;
    logic [CNT_W-1:0] remain_q;
    logic             len_ok;
    logic             last_one;

    assign len_ok   = (cap_len != '0) && (cap_len <= CNT_W'(MAX_COUNT));
    assign last_one = (remain_q == CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE: if (start && len_ok) state_d = CAP_RUN;
            CAP_RUN:  if (last_one)        state_d = CAP_DONE;
            CAP_DONE:                      state_d = CAP_IDLE;
            default:                       state_d = CAP_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    // Remaining-sample counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (state_q == CAP_IDLE) begin
            if (start && len_ok) remain_q <= cap_len;
        end else if (state_q == CAP_RUN) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        valid = 1'b0;
        done  = 1'b0;
        busy  = 1'b1;
        unique case (state_q)
            CAP_IDLE: busy  = 1'b0;
            CAP_RUN:  valid = 1'b1;
            CAP_DONE: done  = 1'b1;
            default:  busy  = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_ddr_capture.sv
module adc_ddr_capture #(
    parameter int SAMPLE_W  = 14,
    parameter int MAX_COUNT = 16384,
    localparam int LINES    = SAMPLE_W / 2,
    localparam int NUM_CH   = 2,
    localparam int CNT_W    = $clog2(MAX_COUNT + 1)
) (
    input  logic                adc_clk,
    input  logic                rst_n,
    input  logic [LINES-1:0]    ddr_a,
    input  logic [LINES-1:0]    ddr_b,
    input  logic                start,
    input  logic [CNT_W-1:0]    cap_len,
    output logic [SAMPLE_W-1:0] samp_a,
    output logic [SAMPLE_W-1:0] samp_b,
    output logic                samp_valid,
    output logic                cap_done,
    output logic                busy
);

    logic [NUM_CH-1:0][LINES-1:0]    lines_in;
    logic [NUM_CH-1:0][SAMPLE_W-1:0] words;

    assign lines_in[0] = ddr_a;
    assign lines_in[1] = ddr_b;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        ddr_lane_capture #(
            .LINES (LINES)
        ) u_lane (
            .clk    (adc_clk),
            .rst_n  (rst_n),
            .ddr_in (lines_in[ch]),
            .word   (words[ch])
        );
    end

    assign samp_a = words[0];
    assign samp_b = words[1];

    capture_sequencer #(
        .MAX_COUNT (MAX_COUNT)
    ) u_seq (
        .clk     (adc_clk),
        .rst_n   (rst_n),
        .start   (start),
        .cap_len (cap_len),
        .valid   (samp_valid),
        .done    (cap_done),
        .busy    (busy)
    );

endmodule

// File: rtl/adc_ddr_capture_chk.sv
module adc_ddr_capture_chk #(
    parameter int MAX_COUNT = 16384,
    localparam int CNT_W = $clog2(MAX_COUNT + 1)
) (
    input logic             adc_clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] cap_len,
    input logic             samp_valid,
    input logic             cap_done,
    input logic             busy
);

    logic             len_ok;
    logic             accept;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] vcnt_q;

    assign len_ok = (cap_len != '0) && (cap_len <= CNT_W'(MAX_COUNT));
    assign accept = !busy && start && len_ok;

    always_ff @(posedge adc_clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            vcnt_q <= '0;
        end else if (accept) begin
            len_q  <= cap_len;
            vcnt_q <= '0;
        end else if (samp_valid) begin
            vcnt_q <= vcnt_q + CNT_W'(1);
        end
    end

    p_accept_r6: assert property (@(posedge adc_clk) disable iff (!rst_n)
        accept |=> samp_valid);

    p_count_len_r8: assert property (@(posedge adc_clk) disable iff (!rst_n)
        cap_done |-> (vcnt_q == len_q));

    p_done_after_valid_r7: assert property (@(posedge adc_clk) disable iff (!rst_n)
        cap_done |-> $past(samp_valid));

    p_done_single_r7: assert property (@(posedge adc_clk) disable iff (!rst_n)
        cap_done |=> (!cap_done && !busy));

    p_no_overlap_r7: assert property (@(posedge adc_clk) disable iff (!rst_n)
        !(samp_valid && cap_done));

    p_reject_r9: assert property (@(posedge adc_clk) disable iff (!rst_n)
        (!busy && start && !len_ok) |=> !busy);

    p_valid_busy_r10: assert property (@(posedge adc_clk) disable iff (!rst_n)
        samp_valid |-> busy);

endmodule

bind adc_ddr_capture adc_ddr_capture_chk #(
    .MAX_COUNT (MAX_COUNT)
) u_chk (
    .adc_clk    (adc_clk),
    .rst_n      (rst_n),
    .start      (start),
    .cap_len    (cap_len),
    .samp_valid (samp_valid),
    .cap_done   (cap_done),
    .busy       (busy)
);

// File: tb/test_adc_ddr_capture.sv
module test_adc_ddr_capture;

    localparam int SW = 14;
    localparam int LN = 7;

    logic          adc_clk = 1'b0;
    logic          rst_n   = 1'b0;
    logic [LN-1:0] ddr_a   = '0;
    logic [LN-1:0] ddr_b   = '0;
    logic          start   = 1'b0;
    logic [14:0]   cap_len = '0;
    logic [SW-1:0] samp_a;
    logic [SW-1:0] samp_b;
    logic          samp_valid;
    logic          cap_done;
    logic          busy;

    int  checks = 0;
    int  errors = 0;
    int  cyc    = -1;
    bit  chk_en = 1'b0;
    bit  ended  = 1'b0;

    always #4 adc_clk = ~adc_clk;

    adc_ddr_capture i_adc_ddr_capture (
        .adc_clk    (adc_clk),
        .rst_n      (rst_n),
        .ddr_a      (ddr_a),
        .ddr_b      (ddr_b),
        .start      (start),
        .cap_len    (cap_len),
        .samp_a     (samp_a),
        .samp_b     (samp_b),
        .samp_valid (samp_valid),
        .cap_done   (cap_done),
        .busy       (busy)
    );

    // Expected word for channel ch at clock index k
    function automatic logic [SW-1:0] word_at(int ch, int k);
        int idx;
        logic [SW-1:0] a, b;
        if (k < 0) return '0;
        idx = k % 64;
        if (idx == 0)      begin a = 14'h3FFF; b = 14'h0000; end
        else if (idx == 1) begin a = 14'h0000; b = 14'h3FFF; end
        else if (idx == 2) begin a = 14'h2AAA; b = 14'h1555; end
        else if (idx == 3) begin a = 14'h1555; b = 14'h2AAA; end
        else if (idx < 18) begin
            a = 14'(1 << (idx - 4));
            b = 14'(1 << (17 - idx));
        end else begin
            a = 14'((k * 1237 + 91) & 16'h3FFF);
            b = 14'((k * 7919 + 4000) & 16'h3FFF);
        end
        return (ch == 0) ? a : b;
    endfunction

    function automatic logic [LN-1:0] half(logic [SW-1:0] w, bit odd);
        logic [LN-1:0] h;
        for (int j = 0; j < LN; j++) h[j] = w[2*j + (odd ? 1 : 0)];
        return h;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Driver: rising half of word k present at posedge k, falling half at the negedge after
    initial begin
        ddr_a = half(word_at(0, 0), 1'b0);
        ddr_b = half(word_at(1, 0), 1'b0);
        forever begin
            @(posedge adc_clk);
            #1 cyc = cyc + 1;
            #2;
            ddr_a = half(word_at(0, cyc), 1'b1);
            ddr_b = half(word_at(1, cyc), 1'b1);
            @(negedge adc_clk);
            #2;
            ddr_a = half(word_at(0, cyc + 1), 1'b0);
            ddr_b = half(word_at(1, cyc + 1), 1'b0);
        end
    end

    // Stream checker: after posedge k the output holds word k-1 (R1, R2, R3, R4)
    initial begin
        forever begin
            @(posedge adc_clk);
            #3;
            if (chk_en) begin
                check(samp_a == word_at(0, cyc - 1), "R1/R2/R3 chan A", samp_a, word_at(0, cyc - 1));
                check(samp_b == word_at(1, cyc - 1), "R4 chan B", samp_b, word_at(1, cyc - 1));
            end
        end
    end

    task automatic capture(int len, bit ok, int mid_at);
        int vcount;
        @(posedge adc_clk);
        #3;
        start   = 1'b1;
        cap_len = 15'(len);
        @(posedge adc_clk);
        #3;
        start = 1'b0;
        if (!ok) begin
            for (int i = 0; i < 4; i++) begin
                check(!busy && !samp_valid, "R9 rejected length", {busy, samp_valid}, 0);
                @(posedge adc_clk);
                #3;
            end
            return;
        end
        vcount = 0;
        for (int i = 0; i <= len; i++) begin
            if (i < len) begin
                check(samp_valid && !cap_done, "R6 valid window", {samp_valid, cap_done}, 2);
                check(busy, "R10 busy in window", busy, 1);
                if (samp_valid) vcount++;
            end else begin
                check(cap_done && !samp_valid, "R7 done pulse", {cap_done, samp_valid}, 2);
                check(busy, "R10 busy on done", busy, 1);
            end
            start   = (i == mid_at);
            cap_len = (i == mid_at) ? 15'(3) : cap_len;
            @(posedge adc_clk);
            #3;
        end
        start = 1'b0;
        check(vcount == len, "R6/R8 valid count", vcount, len);
        check(!busy && !cap_done && !samp_valid, "R7 idle after done",
              {busy, cap_done, samp_valid}, 0);
    endtask

    initial begin
        #10;
        check(samp_a == 0 && samp_b == 0, "R5 reset words", {samp_a, samp_b}, 0);
        check(!samp_valid && !cap_done && !busy, "R5 reset controls",
              {samp_valid, cap_done, busy}, 0);
        @(posedge adc_clk);
        #3 rst_n = 1'b1;
        repeat (3) @(posedge adc_clk);
        chk_en = 1'b1;
        repeat (70) @(posedge adc_clk);     // full pattern cycle streaming while idle (R3)
        capture(1, 1'b1, -1);               // R6 minimum length
        capture(5, 1'b1, -1);
        capture(37, 1'b1, 4);               // R8 start while busy
        capture(0, 1'b0, -1);               // R9 zero length
        capture(16385, 1'b0, -1);           // R9 over maximum
        capture(16384, 1'b1, 100);          // R6 maximum length, R8
        capture(2, 1'b1, 2);                // R8 start during done cycle
        repeat (5) @(posedge adc_clk);
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1600000;
        if (!ended) begin
            ended = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule